// File: doc/BRIEF.md
# Lockable Multicart Bank Register

This block is the PRG banking controller of a multicart for an 8-bit console. It watches the CPU address bus, the data bus, the read/write strobe and the M2 bus clock. From these it produces the upper PRG ROM address bits. It holds two registers. The outer register picks a 32 KB slice and can be set only once per detected console reset. The inner register adds a one-bank step on top of the outer register and can be changed freely.

The block never sees the console's reset line. It infers a console reset from CPU address line A0. A saturating charge counter rises when odd-address accesses hit the outer register window. It falls by one on every bus cycle with A0 low. While the counter is below 60 % of full scale, both registers and the outer lock are held clear and bus accesses are not latched. Once the counter climbs above that level, the first access to the outer window is latched, whether it is a read or a write. A nonzero value in the low six data bits then freezes the outer register until the counter next drops below the threshold.

All inputs are plain control and status pins sampled on the block clock. There is no streamed data path, so there is no valid/ready handshake and no back-pressure. The M2 input must be synchronous to `clk`, and each M2 phase must last at least one `clk` cycle.

Top module: `lockbank_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `prg_bank` is 0, the charge level is 0 and the outer register is unlocked.
- R2: The outer window is $FF80–$FF9F. Once the detector is released and the lock is clear, any bus cycle in this window, read or write, loads data bits [5:0] into the outer register. `prg_bank` shows the new value after that cycle's M2 falling edge.
- R3: A load into the outer register with any of data bits [5:0] set locks it. While locked, every later outer-window cycle leaves `prg_bank` unchanged. A load of zero does not lock.
- R4: The inner window is $FFE8–$FFEF. A bus cycle there loads data bit 0 into the inner register and never locks. `prg_bank` equals outer + inner, computed as a 7-bit sum.
- R5: At each M2 falling edge, the charge level changes as follows:
  - an outer-window cycle with A0 = 1 adds STEP, saturating at FULL;
  - any cycle with A0 = 0 subtracts 1, stopping at 0;
  - any other cycle leaves the level unchanged.
- R6: While the charge level is below THRESH = FULL·60/100, both registers and the lock are held clear. Window cycles in this state are not latched. The release test uses the level from before that cycle's own charge update.
- R7: When the level falls from THRESH to THRESH−1, the lock and both registers clear. After the level recharges, a new outer load is accepted.
- R8: If outer-window odd accesses come often enough to keep the level at or above THRESH, the lock never clears and `prg_bank` keeps its value.
- R9: Bank 15 is reached by loading outer 14 and then setting inner to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than M2 |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| m2 | input | 1 | CPU M2 bus clock, synchronous to clk |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) strobe |
| prg_bank | output | 7 | PRG bank number, outer plus inner |

## Verification
The M2 falling edge is detected on the first `clk` edge at which `m2` reads low. Register loads and the charge update happen on that same edge. A hold-clear caused by the level dropping below the threshold takes effect one `clk` edge later. The bench keeps the bus stable for two further `clk` cycles after M2 falls, and it samples `prg_bank` on the falling edge of `clk` after the whole bus cycle, so every result is due by then. The threshold boundary is checked exactly: the bench counts the bus cycles from a known saturated level, then checks that the level THRESH still keeps the registers and the level THRESH−1 clears them.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;
  // One sampled CPU bus cycle
  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
    logic        rw;
  } bus_cycle_t;

  function automatic logic in_range(input logic [15:0] a, input int unsigned base,
                                    input int unsigned span);
    return (32'(a) >= base) && (32'(a) < base + span);
  endfunction
endpackage

// File: rtl/lockbank_m2edge.sv
module lockbank_m2edge (
  input  logic clk,
  input  logic rst_n,
  input  logic m2,
  output logic fall
);
  logic m2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m2_q <= 1'b0;
    else        m2_q <= m2;
  end
  assign fall = m2_q & ~m2;
endmodule

// File: rtl/lockbank_charge.sv
module lockbank_charge #(
  parameter int unsigned FULL       = 17900,
  parameter int unsigned STEP       = 2048,
  parameter int unsigned THRESH_PCT = 60,
  localparam int unsigned CW        = $clog2(FULL + 1),
  localparam int unsigned THRESH    = (FULL * THRESH_PCT) / 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          charge,
  input  logic          drain,
  output logic [CW-1:0] level,
  output logic          release_n
);
  localparam logic [CW-1:0] FULL_V = CW'(FULL);
  localparam logic [CW-1:0] HEAD_V = CW'(FULL - STEP);
  localparam logic [CW-1:0] STEP_V = CW'(STEP);
  localparam logic [CW-1:0] THR_V  = CW'(THRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (charge) begin
      if (level > HEAD_V) level <= FULL_V;
      else                level <= level + STEP_V;
    end else if (drain) begin
      if (level != '0) level <= level - 1'b1;
    end
  end

  // high while the detector keeps the registers in reset
  assign release_n = (level < THR_V);
endmodule

// File: rtl/lockbank_outer.sv
module lockbank_outer #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      locked <= 1'b0;
    end else if (clr) begin
      q      <= '0;
      locked <= 1'b0;
    end else if (load && !locked) begin
      q      <= din;
      locked <= |din;
    end
  end
endmodule

// File: rtl/lockbank_inner.sv
module lockbank_inner #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/lockbank_ctrl.sv
module lockbank_ctrl #(
  parameter int unsigned OUTER_W    = 6,
  parameter int unsigned INNER_W    = 1,
  parameter int unsigned FULL       = 17900,
  parameter int unsigned STEP       = 2048,
  parameter int unsigned THRESH_PCT = 60,
  parameter int unsigned OUTER_BASE = 32'hFF80,
  parameter int unsigned OUTER_SPAN = 32,
  parameter int unsigned INNER_BASE = 32'hFFE8,
  parameter int unsigned INNER_SPAN = 8,
  localparam int unsigned BANK_W    = OUTER_W + 1,
  localparam int unsigned CW        = $clog2(FULL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m2,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_rw,
  output logic [BANK_W-1:0] prg_bank
);
  import lockbank_pkg::*;

  bus_cycle_t bus;
  logic       m2_fall;
  logic       hit_outer, hit_inner, a0;
  logic       held;
  logic [CW-1:0] level;
  logic [OUTER_W-1:0] outer_q;
  logic [INNER_W-1:0] inner_q;
  logic       outer_locked;

  assign bus = '{addr: cpu_addr, data: cpu_data, rw: cpu_rw};
  assign a0        = bus.addr[0];
  assign hit_outer = in_range(bus.addr, OUTER_BASE, OUTER_SPAN);
  assign hit_inner = in_range(bus.addr, INNER_BASE, INNER_SPAN);

  lockbank_m2edge u_edge (
    .clk(clk), .rst_n(rst_n), .m2(m2), .fall(m2_fall)
  );

  lockbank_charge #(.FULL(FULL), .STEP(STEP), .THRESH_PCT(THRESH_PCT)) u_charge (
    .clk(clk), .rst_n(rst_n),
    .charge(m2_fall & hit_outer & a0),
    .drain(m2_fall & ~a0),
    .level(level), .release_n(held)
  );

  lockbank_outer #(.W(OUTER_W)) u_outer (
    .clk(clk), .rst_n(rst_n), .clr(held),
    .load(m2_fall & hit_outer),
    .din(bus.data[OUTER_W-1:0]),
    .q(outer_q), .locked(outer_locked)
  );

  lockbank_inner #(.W(INNER_W)) u_inner (
    .clk(clk), .rst_n(rst_n), .clr(held),
    .load(m2_fall & hit_inner),
    .din(bus.data[INNER_W-1:0]),
    .q(inner_q)
  );

  assign prg_bank = BANK_W'(outer_q) + BANK_W'(inner_q);
endmodule

// File: rtl/lockbank_chk.sv
module lockbank_chk #(
  parameter int unsigned OUTER_W = 6,
  parameter int unsigned INNER_W = 1,
  parameter int unsigned FULL    = 17900,
  parameter int unsigned CW      = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               m2_fall,
  input logic               a0,
  input logic               hit_outer,
  input logic [7:0]         data,
  input logic               held,
  input logic [CW-1:0]      level,
  input logic [OUTER_W-1:0] outer_q,
  input logic [INNER_W-1:0] inner_q,
  input logic               locked
);
  assert_level_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= FULL);

  assert_drain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_fall && !a0 && level != '0) |=> (level == $past(level) - 1'b1));

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !held) |=> (held || outer_q == $past(outer_q)));

  assert_lock_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_fall && hit_outer && !held && !locked && |data[OUTER_W-1:0]) |=> locked);

  assert_held_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (outer_q == '0 && inner_q == '0 && !locked));
endmodule

bind lockbank_ctrl lockbank_chk #(
  .OUTER_W(OUTER_W), .INNER_W(INNER_W), .FULL(FULL), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m2_fall(m2_fall), .a0(a0), .hit_outer(hit_outer),
  .data(cpu_data), .held(held), .level(level), .outer_q(outer_q),
  .inner_q(inner_q), .locked(outer_locked)
);

// File: tb/lockbank_ctrl_test.sv
module lockbank_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m2 = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_rw = 1'b1;
  logic [6:0]  prg_bank;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // FULL 100, STEP 25, THRESH 60
  lockbank_ctrl #(.FULL(100), .STEP(25), .THRESH_PCT(60)) uut (
    .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_rw(cpu_rw), .prg_bank(prg_bank)
  );

  task automatic check(input string req, input logic [6:0] exp);
    total++;
    if (prg_bank !== exp) begin
      bad++;
      $display("FAIL %s prg_bank actual=%0d expected=%0d", req, prg_bank, exp);
    end
  endtask

  // one M2 period: two clk high, two clk low, bus stable throughout
  task automatic bus_cyc(input logic [15:0] a, input logic [7:0] d, input logic rw);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rw; m2 = 1'b1;
    repeat (2) @(negedge clk);
    m2 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) bus_cyc(16'h0000, 8'h00, 1'b1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 reset", 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 7'd0);
  endtask

  task automatic t_powerup;
    // level 0 -> 25 -> 50 -> 75, none latched
    bus_cyc(16'hFF81, 8'h05, 1'b0); check("R6 powerup 1", 7'd0);
    bus_cyc(16'hFF83, 8'h05, 1'b0); check("R6 powerup 2", 7'd0);
    bus_cyc(16'hFF85, 8'h07, 1'b0); check("R6 powerup 3", 7'd0);
  endtask

  task automatic t_load_lock;
    bus_cyc(16'hFF81, 8'h00, 1'b1); check("R2 read loads zero", 7'd0);  // 100
    bus_cyc(16'hFF82, 8'h03, 1'b0); check("R2 load 3", 7'd3);           // 99, locked
    bus_cyc(16'hFF81, 8'h09, 1'b0); check("R3 locked odd", 7'd3);        // 100
    bus_cyc(16'hFF9E, 8'h2A, 1'b1); check("R3 locked even read", 7'd3);  // 99
  endtask

  task automatic t_inner;
    bus_cyc(16'hFFE9, 8'h01, 1'b0); check("R4 inner 1", 7'd4);   // 99
    bus_cyc(16'hFFEA, 8'h00, 1'b0); check("R4 inner 0", 7'd3);   // 98
    bus_cyc(16'hFFEB, 8'h01, 1'b0); check("R4 inner again", 7'd4); // 98
    bus_cyc(16'hFFE8, 8'h00, 1'b1); check("R4 inner read", 7'd3);  // 97
  endtask

  task automatic t_unlock;
    bus_cyc(16'hFF81, 8'h11, 1'b0);                         // 100, ignored
    drain(40); check("R7 at threshold kept", 7'd3);         // 60
    drain(1);  check("R7 below threshold cleared", 7'd0);   // 59
    bus_cyc(16'hFF81, 8'h0E, 1'b0); check("R6 recharge not latched", 7'd0); // 84
    bus_cyc(16'hFF80, 8'h0E, 1'b0); check("R7 reload after unlock", 7'd14); // 83
  endtask

  task automatic t_bank15;
    bus_cyc(16'hFFE9, 8'h01, 1'b0); check("R9 bank 15", 7'd15);
  endtask

  task automatic t_no_unlock;
    for (int k = 0; k < 6; k++) begin
      drain(20); check("R8 after drain", 7'd15);
      bus_cyc(16'hFF81, 8'h3F, 1'b0); check("R8 after odd access", 7'd15);
    end
    // level saturated at 100: 40 drains hold, 41st clears
    drain(40); check("R5 saturated then 60", 7'd15);
    drain(1);  check("R5 saturated then 59", 7'd0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_load_lock();
    t_inner();
    t_unlock();
    t_bank15();
    t_no_unlock();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog timeout");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule